// File: doc/BRIEF.md
# Chained Serializer Readout Controller

This block is a serial-bus master that reads a cascade of `NDEV` eight-input industrial serializers in one burst. While the burst runs, chip select stays low, and the block toggles the serial clock until every device in the chain has shifted out its word. When the burst ends, the block latches one aggregate input vector of `8*NDEV` bits, together with a valid, a fault and a warning flag for each device. All of these appear in the same cycle as a one-cycle completion pulse.

Two frame formats are available. In the short format each device returns only its input byte. In the long format each device returns its input byte and then a status byte. The block judges each device on its own. A faulting device has its byte blanked to zero and its valid flag cleared. Healthy devices in the same chain still deliver their data.

The block also does two configuration jobs. It drives the shared mode-select line for the chain. It translates a debounce request, given in microseconds, into a two-bit debounce selection.

Top module: `serchain_rd`

## Requirements
- R1: While reset is active, the outputs hold these values: `csN`=1, `sclk`=0, `busy`=0, `done`=0, `dbReject`=0, `modeSel`=1, and `inBits`, `devValid`, `devFault`, `devWarn` and `dbSel` are all zero.
- R2: A `start` pulse seen while idle launches a burst. `csN` falls at that clock edge and stays low for the whole burst. `sclk` starts low and toggles every `HALF` clocks. `miso` is sampled on each rising `sclk`. A `start` seen while a burst runs is ignored.
- R3: The burst carries `8*NDEV` bits when `longFrame`=0 and `16*NDEV` bits when `longFrame`=1. The format is sampled with `start`, so `csN` is low for `2*HALF*bits` clocks.
- R4: Bits arrive MSB first, and the first byte belongs to device 0. In the long format, device i's data byte comes before its status byte. Bit k of `inBits` is bit k mod 8 of device k/8's data byte.
- R5: `done` is high for exactly one clock. It rises in the cycle in which `csN` returns high, and the new result vectors become visible in that same cycle. The result vectors hold their values until the next burst completes.
- R6: In the short format, the only cause of a fault is the device's fault line (`faultIn`, active high). Status content and `crcBad` are ignored.
- R7: In the long format, a device faults if any of these holds: its fault line is 1, status bit 1 (overtemperature) is 1, status bit 2 (supply alarm, active low) is 0, or `crcBad[i]` is 1. Status bit 0 = 0 sets `devWarn[i]` without causing a fault.
- R8: When `ignoreUv`=1, the supply alarm, the supply warning and the fault lines all have no effect.
- R9: When `faultShared`=1, `faultIn[0]` stands for every device. When `faultShared`=0, `faultIn[i]` belongs to device i.
- R10: A faulting device reads `devValid[i]`=0, `devFault[i]`=1 and data byte 0x00. A healthy device reads `devValid[i]`=1 with its received byte.
- R11: A `dbWr` strobe maps `dbReq` onto `dbSel` = {first, second} on the next clock. A request of 0 gives 00, 1 to 25 gives 01, 26 to 750 gives 10, and 751 to 3000 gives 11.
- R12: A `dbWr` with `dbReq` above 3000 leaves `dbSel` unchanged and pulses `dbReject` for one clock.
- R13: While idle, `modeSel` follows the inverse of `longFrame` (1 for short, 0 for long) with one clock of delay. It does not change during a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one readout burst |
| longFrame | input | 1 | 1 selects data plus status per device |
| ignoreUv | input | 1 | Suppress supply diagnostics and fault lines |
| faultShared | input | 1 | 1: faultIn[0] serves all devices |
| faultIn | input | NDEV | Per-device fault lines, active high |
| crcBad | input | NDEV | Status check result from the external checker |
| miso | input | 1 | Serial data from the chain |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 1 | Chip select, active low |
| modeSel | output | 1 | Chain mode line, 1 = short format |
| dbWr | input | 1 | Debounce request strobe |
| dbReq | input | REQW | Debounce request in microseconds |
| dbSel | output | 2 | Debounce selection pair |
| dbReject | output | 1 | Out-of-range debounce request pulse |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst complete, results valid |
| inBits | output | 8*NDEV | Aggregate input vector |
| devValid | output | NDEV | Per-device data valid |
| devFault | output | NDEV | Per-device fault |
| devWarn | output | NDEV | Per-device supply warning |

## Verification
A new `start` can arrive in the same cycle as the `done` pulse of the previous burst. The controller must accept it without disturbing the results it has just presented. The bench provokes this by driving `start` in the very cycle that `done` is first observed high. In that case the `done` cycle must still show the first burst's results, and the second burst must then run to its full, format-dependent length. A `start` issued in the middle of a burst is also driven, and it must leave both the burst timing and `modeSel` untouched. Every output is compared against the behavioural model on every clock.

// File: rtl/serchain_pkg.sv
package serchain_pkg;
  typedef struct packed {
    logic launch;
    logic shiftEn;
    logic capture;
  } strobe_t;
endpackage

// File: rtl/serchain_ctrl.sv
module serchain_ctrl
  import serchain_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int HALF = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    longFrame,
  output strobe_t strb,
  output logic    longQ,
  output logic    sclk,
  output logic    csN,
  output logic    busy,
  output logic    done,
  output logic    modeSel
);
  localparam int BITS_MAX = 16 * NDEV;
  localparam int BW = $clog2(BITS_MAX);
  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [BW-1:0] LAST_SHORT = BW'(8 * NDEV - 1);
  localparam logic [BW-1:0] LAST_LONG  = BW'(16 * NDEV - 1);
  localparam logic [DW-1:0] DIV_END    = DW'(HALF - 1);

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;

  state_t        state;
  logic [DW-1:0] divCnt;
  logic [BW-1:0] bitCnt;
  logic          sclkQ;
  logic          doneQ;
  logic          modeQ;
  logic          phaseEnd;
  logic          lastBit;

  assign phaseEnd = (divCnt == DIV_END);
  assign lastBit  = (bitCnt == (longQ ? LAST_LONG : LAST_SHORT));

  always_comb begin
    strb         = '0;
    strb.launch  = (state == ST_IDLE) && start;
    strb.shiftEn = (state == ST_SHIFT) && phaseEnd && !sclkQ;
    strb.capture = (state == ST_SHIFT) && phaseEnd && sclkQ && lastBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      sclkQ  <= 1'b0;
      doneQ  <= 1'b0;
      longQ  <= 1'b0;
      modeQ  <= 1'b1;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          modeQ <= ~longFrame;
          if (start) begin
            state  <= ST_SHIFT;
            longQ  <= longFrame;
            divCnt <= '0;
            bitCnt <= '0;
            sclkQ  <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (phaseEnd) begin
            divCnt <= '0;
            sclkQ  <= ~sclkQ;
            if (sclkQ) begin
              if (lastBit) begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclkQ;
  assign csN     = (state == ST_IDLE);
  assign busy    = (state == ST_SHIFT);
  assign done    = doneQ;
  assign modeSel = modeQ;

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk);
  assert_cs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csN) |-> done);
  assert_mode_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(modeSel));
endmodule

// File: rtl/serchain_dp.sv
module serchain_dp
  import serchain_pkg::*;
#(
  parameter int NDEV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic              miso,
  input  logic              longQ,
  input  logic              ignoreUv,
  input  logic              faultShared,
  input  logic [NDEV-1:0]   faultIn,
  input  logic [NDEV-1:0]   crcBad,
  output logic [8*NDEV-1:0] inBits,
  output logic [NDEV-1:0]   devValid,
  output logic [NDEV-1:0]   devFault,
  output logic [NDEV-1:0]   devWarn
);
  localparam int SRW = 16 * NDEV;

  logic [SRW-1:0]    shiftQ;
  logic [8*NDEV-1:0] nxtBits;
  logic [NDEV-1:0]   nxtFault;
  logic [NDEV-1:0]   nxtWarn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftQ <= '0;
    end else if (strb.launch) begin
      shiftQ <= '0;
    end else if (strb.shiftEn) begin
      shiftQ <= {shiftQ[SRW-2:0], miso};
    end
  end

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic [7:0] dataLong, statLong, dataShort, dataSel;
    logic       pinRaw, pinFault, uvAlarm, overTemp, faultAny;

    assign dataLong  = shiftQ[(2*NDEV-1-2*i)*8 +: 8];
    assign statLong  = shiftQ[(2*NDEV-2-2*i)*8 +: 8];
    assign dataShort = shiftQ[(NDEV-1-i)*8 +: 8];
    assign dataSel   = longQ ? dataLong : dataShort;

    assign pinRaw   = faultShared ? faultIn[0] : faultIn[i];
    assign pinFault = pinRaw & ~ignoreUv;
    assign uvAlarm  = ~statLong[2] & ~ignoreUv;
    assign overTemp = statLong[1];
    assign faultAny = pinFault | (longQ & (overTemp | uvAlarm | crcBad[i]));

    assign nxtFault[i]       = faultAny;
    assign nxtWarn[i]        = longQ & ~ignoreUv & ~statLong[0];
    assign nxtBits[i*8 +: 8] = faultAny ? 8'h00 : dataSel;

    assert_fault_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      devFault[i] |-> (inBits[i*8 +: 8] == 8'h00));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inBits   <= '0;
      devValid <= '0;
      devFault <= '0;
      devWarn  <= '0;
    end else if (strb.capture) begin
      inBits   <= nxtBits;
      devValid <= ~nxtFault;
      devFault <= nxtFault;
      devWarn  <= nxtWarn;
    end
  end

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.capture |=> $stable({inBits, devValid, devFault, devWarn}));
  assert_valid_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (devValid & devFault) == '0);
endmodule

// File: rtl/serchain_dbnc.sv
module serchain_dbnc #(
  parameter int REQW = 12,
  parameter int LIM1 = 25,
  parameter int LIM2 = 750,
  parameter int LIM3 = 3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbWr,
  input  logic [REQW-1:0] dbReq,
  output logic [1:0]      dbSel,
  output logic            dbReject
);
  logic [1:0] code;
  logic       outOfRange;

  assign outOfRange = (dbReq > REQW'(LIM3));

  always_comb begin
    if (dbReq == '0)                code = 2'b00;
    else if (dbReq <= REQW'(LIM1))  code = 2'b01;
    else if (dbReq <= REQW'(LIM2))  code = 2'b10;
    else                            code = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbSel    <= 2'b00;
      dbReject <= 1'b0;
    end else begin
      dbReject <= 1'b0;
      if (dbWr) begin
        if (outOfRange) dbReject <= 1'b1;
        else            dbSel    <= code;
      end
    end
  end

  assert_reject_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dbReject |-> $stable(dbSel));
endmodule

// File: rtl/serchain_rd.sv
module serchain_rd
  import serchain_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int HALF = 2,
  parameter int REQW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              longFrame,
  input  logic              ignoreUv,
  input  logic              faultShared,
  input  logic [NDEV-1:0]   faultIn,
  input  logic [NDEV-1:0]   crcBad,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              modeSel,
  input  logic              dbWr,
  input  logic [REQW-1:0]   dbReq,
  output logic [1:0]        dbSel,
  output logic              dbReject,
  output logic              busy,
  output logic              done,
  output logic [8*NDEV-1:0] inBits,
  output logic [NDEV-1:0]   devValid,
  output logic [NDEV-1:0]   devFault,
  output logic [NDEV-1:0]   devWarn
);
  strobe_t strb;
  logic    longQ;

  serchain_ctrl #(.NDEV(NDEV), .HALF(HALF)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .longFrame(longFrame),
    .strb(strb), .longQ(longQ), .sclk(sclk), .csN(csN), .busy(busy),
    .done(done), .modeSel(modeSel)
  );

  serchain_dp #(.NDEV(NDEV)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .miso(miso), .longQ(longQ),
    .ignoreUv(ignoreUv), .faultShared(faultShared), .faultIn(faultIn),
    .crcBad(crcBad), .inBits(inBits), .devValid(devValid),
    .devFault(devFault), .devWarn(devWarn)
  );

  serchain_dbnc #(.REQW(REQW)) u_dbnc (
    .clk(clk), .rst_n(rst_n), .dbWr(dbWr), .dbReq(dbReq),
    .dbSel(dbSel), .dbReject(dbReject)
  );
endmodule

// File: tb/sim_serchain_rd.sv
`timescale 1ns/1ps
module sim_serchain_rd;
  localparam int NDEV = 4;
  localparam int HALF = 2;

  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, start = 0, longFrame = 0, ignoreUv = 0, faultShared = 0;
  logic [NDEV-1:0] faultIn = '0, crcBad = '0;
  logic miso = 0, dbWr = 0;
  logic [11:0] dbReq = '0;
  logic sclk, csN, modeSel, dbReject, busy, done;
  logic [1:0] dbSel;
  logic [8*NDEV-1:0] inBits;
  logic [NDEV-1:0] devValid, devFault, devWarn;

  serchain_rd #(.NDEV(NDEV), .HALF(HALF), .REQW(12)) u0 (.*);

  logic [7:0] devData [NDEV];
  logic [7:0] devStat [NDEV];
  int vecs = 0, fails = 0;
  bit running = 0, ended = 0;
  string scenTag = "R6";

  // behavioural model state
  bit mBusy = 0, mDone = 0, mLong = 0, mMode = 1, mRej = 0;
  int mT = 0;
  logic [8*NDEV-1:0] mIn = '0;
  logic [NDEV-1:0] mValid = '0, mFault = '0, mWarn = '0;
  logic [1:0] mDb = '0;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp,
                     input string tag, input string what);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] dbMap(input int v);
    if (v == 0) return 2'b00;
    if (v <= 25) return 2'b01;
    if (v <= 750) return 2'b10;
    return 2'b11;
  endfunction

  function automatic void finishBurst();
    for (int i = 0; i < NDEV; i++) begin
      bit pin, f, w;
      pin = faultShared ? faultIn[0] : faultIn[i];
      f = pin && !ignoreUv;
      w = 0;
      if (mLong) begin
        if (devStat[i][1]) f = 1;
        if (!devStat[i][2] && !ignoreUv) f = 1;
        if (crcBad[i]) f = 1;
        w = !devStat[i][0] && !ignoreUv;
      end
      mFault[i] = f;
      mValid[i] = !f;
      mWarn[i] = w;
      mIn[i*8 +: 8] = f ? 8'h00 : devData[i];
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mBusy = 0; mDone = 0; mMode = 1; mRej = 0; mT = 0;
      mIn = '0; mValid = '0; mFault = '0; mWarn = '0; mDb = '0;
    end else begin
      mDone = 0;
      mRej = 0;
      if (!mBusy) mMode = !longFrame;
      if (!mBusy && start) begin
        mBusy = 1; mT = 0; mLong = longFrame;
      end else if (mBusy) begin
        mT++;
        if (mT == 2 * HALF * 8 * NDEV * (mLong ? 2 : 1)) begin
          mBusy = 0; mDone = 1; finishBurst();
        end
      end
      if (dbWr) begin
        if (dbReq > 3000) mRej = 1;
        else mDb = dbMap(int'(dbReq));
      end
    end
  end

  // slave model and per-clock comparison
  bit prevCs = 1, prevSclk = 0;
  int sIdx = 0;
  function automatic logic streamBit(input int idx);
    int j;
    logic [7:0] b;
    j = idx / 8;
    if (mLong) b = (j >= 2*NDEV) ? 8'h00 : ((j % 2 == 0) ? devData[j/2] : devStat[j/2]);
    else       b = (j >= NDEV) ? 8'h00 : devData[j];
    return b[7 - idx % 8];
  endfunction

  always @(negedge clk) begin
    if (running && !ended) begin
      chk(csN, !mBusy, "R2 R3", "csN");
      chk(sclk, mBusy && ((mT / HALF) % 2 == 1), "R2", "sclk");
      chk(busy, mBusy, "R2", "busy");
      chk(done, mDone, "R5", "done");
      chk(modeSel, mMode, "R13", "modeSel");
      chk(dbSel, mDb, "R11", "dbSel");
      chk(dbReject, mRej, "R12", "dbReject");
      chk(inBits, mIn, "R4", "inBits");
      chk(devValid, mValid, "R10", "devValid");
      chk(devFault, mFault, scenTag, "devFault");
      chk(devWarn, mWarn, scenTag, "devWarn");
    end
    if (prevCs && !csN) sIdx = 0;
    else if (!csN && prevSclk && !sclk) sIdx++;
    miso = streamBit(sIdx);
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic burst(input bit lf);
    @(negedge clk);
    longFrame = lf;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dbw(input int v);
    @(negedge clk);
    dbReq = 12'(v);
    dbWr = 1;
    @(negedge clk);
    dbWr = 0;
    @(negedge clk);
  endtask

  task automatic summary();
    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NDEV; i++) begin devData[i] = 8'h00; devStat[i] = 8'h05; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(csN, 1, "R1", "csN"); chk(sclk, 0, "R1", "sclk");
    chk(busy, 0, "R1", "busy"); chk(done, 0, "R1", "done");
    chk(modeSel, 1, "R1", "modeSel"); chk(dbSel, 0, "R1", "dbSel");
    chk(dbReject, 0, "R1", "dbReject"); chk(inBits, 0, "R1", "inBits");
    chk(devValid, 0, "R1", "devValid"); chk(devFault, 0, "R1", "devFault");
    chk(devWarn, 0, "R1", "devWarn");
    rst_n = 1;
    running = 1;

    // R6 short clean
    devData[0] = 8'hA5; devData[1] = 8'h3C; devData[2] = 8'h81; devData[3] = 8'h7E;
    scenTag = "R6";
    burst(0);
    // R7 long clean
    devData[0] = 8'h12; devData[1] = 8'hF0; devData[2] = 8'h0F; devData[3] = 8'hC3;
    scenTag = "R7";
    burst(1);
    // R7 long diagnostics
    devStat[0] = 8'h05; crcBad = 4'b0001;
    devStat[1] = 8'h07; devStat[2] = 8'h01; devStat[3] = 8'h04;
    devData[0] = 8'h5A; devData[1] = 8'h99; devData[2] = 8'h66; devData[3] = 8'hE1;
    burst(1);
    // R8 ignore supply and fault lines
    scenTag = "R8";
    ignoreUv = 1; faultIn = 4'b1000;
    burst(1);
    // R6 short: status and crc ignored, pins per device
    scenTag = "R6";
    ignoreUv = 0; crcBad = 4'b1111; faultIn = 4'b0101;
    devData[0] = 8'h01; devData[1] = 8'h80; devData[2] = 8'hFF; devData[3] = 8'h24;
    burst(0);
    // R9 shared fault line
    scenTag = "R9";
    crcBad = '0; faultShared = 1; faultIn = 4'b0001;
    burst(0);
    faultIn = 4'b1110;
    burst(0);
    faultShared = 0; faultIn = '0;
    for (int i = 0; i < NDEV; i++) devStat[i] = 8'h05;
    // R2 start during busy ignored; R13 mode held
    scenTag = "R2";
    @(negedge clk); longFrame = 1; start = 1;
    @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    longFrame = 0; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    // R5 start in the same cycle as done
    scenTag = "R5";
    devData[2] = 8'h3B;
    start = 1; longFrame = 0;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    // R11 R12 debounce mapping, including a write during a burst
    dbw(0); dbw(1); dbw(25); dbw(26); dbw(750); dbw(751); dbw(3000);
    dbw(3001); dbw(4095); dbw(26); dbw(3001); dbw(0);
    @(negedge clk); longFrame = 1; start = 1;
    @(negedge clk); start = 0; dbReq = 12'd800; dbWr = 1;
    @(negedge clk); dbWr = 0;
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=finished");
      summary();
    end
  end
endmodule